// File: doc/BRIEF.md
# Multiplexed Pixel Input Demultiplexer

This block sits behind a narrow 12-bit pixel input port. Each pixel crosses the port as two consecutive half-words, a first half and a second half. The block pairs them up again and emits one registered 24-bit pixel with a one-cycle valid strobe. A two-bit format select sets how the halves are unpacked. There are three packings: a 16-bit RGB packing, a 15-bit RGB packing, and an 8-bit luma/chroma packing in which the chroma samples alternate between Cb and Cr from pixel to pixel.

The port clock normally runs at twice the pixel rate, with one half-word per rising edge. A pixel-rate mode is also supported. In that mode one half-word is taken on each clock edge, and a polarity bit sets which edge carries the first half. A rising edge on the horizontal sync input starts a new line. It forces the word phase back to the first half and restarts the chroma alternation at Cb, so a misaligned word stream recovers at every line.

Top module: `mux_pixel_unpack`

## Requirements
- R1: In double-rate mode (`rate_1x`=0), words are taken on rising edges and alternate first half, second half. `pix_valid` is high for exactly the one cycle after the rising edge that takes a second half, and low in the cycle after a first half.
- R2: With `fmt`=0 (16-bit RGB), `pix[23:19]`=b[11:7], `pix[15:10]`={b[6:4],a[11:9]}, `pix[7:3]`=a[8:4]. Bits [18:16], [9:8] and [2:0] are zero. Here a is the first half and b is the second half.
- R3: With `fmt`=1 (15-bit RGB), `pix[23:19]`=b[10:6], `pix[15:11]`={b[5:4],a[11:9]}, `pix[7:3]`=a[8:4]. Bits [18:16], [10:8] and [2:0] are zero.
- R4: With `fmt`=2 (luma/chroma), `pix[23:16]`=b[7:0] (luma), `pix[15:8]`=a[7:0] (chroma), and `pix[7:0]` is zero. Half-word bits [11:8] are not used.
- R5: With `fmt`=3 (reserved), a completed pixel is presented as all zeros with `pix_valid` still asserted.
- R6: On the rising edge of the clock where `hsync` is first seen high after being low, the current word is discarded and no pixel completes. The next word is taken as a first half.
- R7: `chroma_cr` (0 = Cb, 1 = Cr) is 0 on the first valid pixel after a line start. It toggles from one valid pixel to the next and holds its value while `pix_valid` is low.
- R8: In pixel-rate mode (`rate_1x`=1) with `clk_inv`=0, the first half is taken on the falling edge and the second half on the following rising edge. A pixel completes on every rising edge.
- R9: In pixel-rate mode with `clk_inv`=1, the first half is taken on a rising edge and the second half on the following falling edge. The pixel completes on the next rising edge.
- R10: While `rst` is high at a rising edge, `pix`, `pix_valid` and `chroma_cr` are cleared to zero and the word phase returns to the first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, double or single pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| rate_1x | input | 1 | 1 = pixel-rate clock with one half-word per edge |
| clk_inv | input | 1 | In pixel-rate mode, 1 = first half on the rising edge |
| fmt | input | 2 | Packing: 0 RGB16, 1 RGB15, 2 luma/chroma, 3 reserved |
| hsync | input | 1 | Horizontal sync, rising edge starts a line |
| din | input | 12 | Half-word data |
| pix | output | 24 | Assembled pixel |
| pix_valid | output | 1 | One-cycle strobe for a new pixel |
| chroma_cr | output | 1 | Chroma component of the current pixel, 1 = Cr |

## Verification
The bench builds the block with its defaults, including `SUPPORT_1X`=1. That setting instantiates the falling-edge capture register, so both pixel-rate polarities can be driven alongside the double-rate path. With the pixel-rate option compiled in, a single build covers all three capture paths: double rate, falling-then-rising, and rising-then-falling. It also covers every format code, line-start realignment in the middle of a pixel, and the chroma alternation restarting at Cb.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam int HALF_W = 12;
  localparam int PIX_W  = 24;
  localparam int FMT_W  = 2;

  typedef enum logic [FMT_W-1:0] {
    FMT_RGB16 = 2'd0,
    FMT_RGB15 = 2'd1,
    FMT_YCC   = 2'd2,
    FMT_RSVD  = 2'd3
  } fmt_e;
endpackage

// File: rtl/pdm_phase.sv
// Line-start detection and half-word phase tracking.
module pdm_phase (
  input  logic clk,
  input  logic rst,
  input  logic hsync,
  input  logic rate_1x,
  output logic line_start,
  output logic take_first,
  output logic complete
);
  logic hs_d;
  logic second;   // 1: next rising-edge word is a second half

  assign line_start = hsync & ~hs_d;
  assign take_first = ~line_start & ~rate_1x & ~second;
  assign complete   = ~line_start & (rate_1x | second);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_d   <= 1'b0;
      second <= 1'b0;
    end else begin
      hs_d <= hsync;
      if (line_start || rate_1x) second <= 1'b0;
      else                       second <= ~second;
    end
  end
endmodule

// File: rtl/pdm_halves.sv
// Holds the first half and selects both halves for the completing edge.
module pdm_halves #(
  parameter int  W          = 12,
  parameter bit  SUPPORT_1X = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rate_1x,
  input  logic         clk_inv,
  input  logic         take_first,
  input  logic [W-1:0] din,
  output logic [W-1:0] half_a,
  output logic [W-1:0] half_b
);
  logic [W-1:0] rise_q;

  generate
    if (SUPPORT_1X) begin : g_ddr
      logic [W-1:0] fall_q;

      always_ff @(posedge clk) begin
        if (rst)                        rise_q <= '0;
        else if (take_first || rate_1x) rise_q <= din;
      end

      always_ff @(negedge clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= din;
      end

      always_comb begin
        if (!rate_1x) begin
          half_a = rise_q;
          half_b = din;
        end else if (clk_inv) begin
          half_a = rise_q;
          half_b = fall_q;
        end else begin
          half_a = fall_q;
          half_b = din;
        end
      end
    end else begin : g_sdr
      logic unused_mode;
      assign unused_mode = rate_1x ^ clk_inv;

      always_ff @(posedge clk) begin
        if (rst)             rise_q <= '0;
        else if (take_first) rise_q <= din;
      end

      assign half_a = rise_q;
      assign half_b = din;
    end
  endgenerate
endmodule

// File: rtl/pdm_pack.sv
// Format-dependent bit placement of the two halves.
module pdm_pack
  import pdm_pkg::*;
(
  input  logic [FMT_W-1:0]  fmt,
  input  logic [HALF_W-1:0] a,
  input  logic [HALF_W-1:0] b,
  output logic [PIX_W-1:0]  pix
);
  logic unused_bits;
  assign unused_bits = ^a[3:0] ^ ^b[3:0];

  always_comb begin
    pix = '0;
    case (fmt_e'(fmt))
      FMT_RGB16: begin
        pix[23:19] = b[11:7];
        pix[15:10] = {b[6:4], a[11:9]};
        pix[7:3]   = a[8:4];
      end
      FMT_RGB15: begin
        pix[23:19] = b[10:6];
        pix[15:11] = {b[5:4], a[11:9]};
        pix[7:3]   = a[8:4];
      end
      FMT_YCC: begin
        pix[23:16] = b[7:0];
        pix[15:8]  = a[7:0];
      end
      default: pix = '0;
    endcase
  end
endmodule

// File: rtl/mux_pixel_unpack.sv
module mux_pixel_unpack
  import pdm_pkg::*;
#(
  parameter bit SUPPORT_1X = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rate_1x,
  input  logic                 clk_inv,
  input  logic [FMT_W-1:0]     fmt,
  input  logic                 hsync,
  input  logic [HALF_W-1:0]    din,
  output logic [PIX_W-1:0]     pix,
  output logic                 pix_valid,
  output logic                 chroma_cr
);
  logic              line_start, take_first, complete;
  logic [HALF_W-1:0] half_a, half_b;
  logic [PIX_W-1:0]  packed_pix;
  logic              next_cr;

  pdm_phase u_phase (
    .clk        (clk),
    .rst        (rst),
    .hsync      (hsync),
    .rate_1x    (rate_1x),
    .line_start (line_start),
    .take_first (take_first),
    .complete   (complete)
  );

  pdm_halves #(.W(HALF_W), .SUPPORT_1X(SUPPORT_1X)) u_halves (
    .clk        (clk),
    .rst        (rst),
    .rate_1x    (rate_1x),
    .clk_inv    (clk_inv),
    .take_first (take_first),
    .din        (din),
    .half_a     (half_a),
    .half_b     (half_b)
  );

  pdm_pack u_pack (
    .fmt (fmt),
    .a   (half_a),
    .b   (half_b),
    .pix (packed_pix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix       <= '0;
      pix_valid <= 1'b0;
      chroma_cr <= 1'b0;
      next_cr   <= 1'b0;
    end else begin
      pix_valid <= complete;
      if (line_start) next_cr <= 1'b0;
      if (complete) begin
        pix       <= packed_pix;
        chroma_cr <= next_cr;
        next_cr   <= ~next_cr;
      end
    end
  end
endmodule

// File: rtl/pdm_checker.sv
module pdm_checker (
  input logic        clk,
  input logic        rst,
  input logic        rate_1x,
  input logic [1:0]  fmt,
  input logic        hsync,
  input logic [23:0] pix,
  input logic        pix_valid,
  input logic        chroma_cr
);
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !$past(rate_1x) && !$past(rate_1x, 2)) |-> !$past(pix_valid)); // R1

  AST_RGB16_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(fmt) == 2'd0) |-> (pix[18:16] == 3'd0 && pix[9:8] == 2'd0 && pix[2:0] == 3'd0)); // R2

  AST_RGB15_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(fmt) == 2'd1) |-> (pix[18:16] == 3'd0 && pix[10:8] == 3'd0 && pix[2:0] == 3'd0)); // R3

  AST_YCC_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(fmt) == 2'd2) |-> (pix[7:0] == 8'd0)); // R4

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(fmt) == 2'd3) |-> (pix == 24'd0)); // R5

  AST_LINE_START_DROP: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |=> !pix_valid); // R6

  AST_CHROMA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> $stable(chroma_cr)); // R7
endmodule

bind mux_pixel_unpack pdm_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .rate_1x   (rate_1x),
  .fmt       (fmt),
  .hsync     (hsync),
  .pix       (pix),
  .pix_valid (pix_valid),
  .chroma_cr (chroma_cr)
);

// File: tb/tb_mux_pixel_unpack.sv
module tb_mux_pixel_unpack;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rate_1x = 1'b0;
  logic        clk_inv = 1'b0;
  logic [1:0]  fmt = 2'd0;
  logic        hsync = 1'b0;
  logic [11:0] din = 12'd0;
  logic [23:0] pix;
  logic        pix_valid;
  logic        chroma_cr;

  int n_chk  = 0;
  int n_fail = 0;
  logic exp_cr = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  mux_pixel_unpack dut (
    .clk(clk), .rst(rst), .rate_1x(rate_1x), .clk_inv(clk_inv), .fmt(fmt),
    .hsync(hsync), .din(din), .pix(pix), .pix_valid(pix_valid), .chroma_cr(chroma_cr)
  );

  // {fmt, first half, second half, expected pixel}
  localparam int NV = 7;
  localparam logic [49:0] VEC [NV] = '{
    {2'd0, 12'hFFF, 12'h000, 24'h001CF8},
    {2'd0, 12'h000, 12'hFFF, 24'hF8E000},
    {2'd1, 12'h000, 12'hFFF, 24'hF8C000},
    {2'd1, 12'hFFF, 12'h000, 24'h0038F8},
    {2'd2, 12'h0A5, 12'hF3C, 24'h3CA500},
    {2'd2, 12'hF12, 12'hF34, 24'h341200},
    {2'd3, 12'hFFF, 12'hFFF, 24'h000000}
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string fmt_req(input logic [1:0] f);
    case (f)
      2'd0:    return "R2 rgb16 packing";
      2'd1:    return "R3 rgb15 packing";
      2'd2:    return "R4 luma/chroma packing";
      default: return "R5 reserved format";
    endcase
  endfunction

  // Entered and left at a falling edge.
  task automatic pair(input logic [1:0] f, input logic [11:0] a, input logic [11:0] b,
                      input logic [23:0] e);
    fmt = f;
    din = a;
    @(negedge clk);
    chk("R1 no valid after first half", {23'd0, pix_valid}, 24'd0);
    din = b;
    @(negedge clk);
    chk("R1 valid after second half", {23'd0, pix_valid}, 24'd1);
    chk(fmt_req(f), pix, e);
    chk("R7 chroma phase", {23'd0, chroma_cr}, {23'd0, exp_cr});
    exp_cr = ~exp_cr;
  endtask

  task automatic line_start();
    hsync = 1'b1;
    @(negedge clk);
    chk("R6 no valid on line start", {23'd0, pix_valid}, 24'd0);
    hsync = 1'b0;
    exp_cr = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset pix", pix, 24'd0);
    chk("R10 reset valid", {23'd0, pix_valid}, 24'd0);
    chk("R10 reset chroma", {23'd0, chroma_cr}, 24'd0);
    rst = 1'b0;
    @(negedge clk);

    line_start();
    for (int i = 0; i < NV; i++)
      pair(VEC[i][49:48], VEC[i][47:36], VEC[i][35:24], VEC[i][23:0]);

    // Half a pixel, then a line start: phase must realign (R6) and chroma restart (R7).
    fmt = 2'd2;
    din = 12'hABC;
    @(negedge clk);
    chk("R1 no valid after first half", {23'd0, pix_valid}, 24'd0);
    line_start();
    pair(2'd2, 12'h012, 12'h034, 24'h341200);
    pair(2'd2, 12'h0C0, 12'h080, 24'h80C000);
    // Chroma must hold across idle cycles (R7)
    @(negedge clk);
    chk("R7 chroma holds while idle", {23'd0, chroma_cr}, 24'd1);
    line_start();
    pair(2'd0, 12'hFFF, 12'h000, 24'h001CF8);

    // Pixel-rate mode, first half on falling edge (R8)
    rate_1x = 1'b1;
    clk_inv = 1'b0;
    fmt = 2'd2;
    @(posedge clk); #2 din = 12'h055;
    @(negedge clk); #2 din = 12'h0AA;
    @(negedge clk);
    chk("R8 pixel-rate falling-first pix", pix, 24'hAA5500);
    chk("R8 pixel-rate valid", {23'd0, pix_valid}, 24'd1);
    @(posedge clk); #2 din = 12'hFFF;
    @(negedge clk); #2 din = 12'h000;
    fmt = 2'd0;
    @(negedge clk);
    chk("R8 pixel-rate rgb16 pix", pix, 24'h001CF8);

    // Pixel-rate mode, first half on rising edge (R9)
    clk_inv = 1'b1;
    fmt = 2'd2;
    #2 din = 12'h011;
    @(posedge clk); #2 din = 12'h022;
    @(posedge clk);
    @(negedge clk);
    chk("R9 pixel-rate rising-first pix", pix, 24'h221100);
    chk("R9 pixel-rate valid", {23'd0, pix_valid}, 24'd1);
    #2 din = 12'h000;
    fmt = 2'd1;
    @(posedge clk); #2 din = 12'hFFF;
    @(posedge clk);
    @(negedge clk);
    chk("R9 pixel-rate rgb15 pix", pix, 24'hF8C000);

    // Reset mid-stream clears outputs (R10)
    rst = 1'b1;
    @(negedge clk);
    chk("R10 reset clears pix", pix, 24'd0);
    chk("R10 reset clears valid", {23'd0, pix_valid}, 24'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule